// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

A purely combinational unit that corrects an accumulator byte pair after binary addition or subtraction of decimal digits. It takes a low byte, a high byte, the incoming carry and half-carry flags and a two-bit operation code. It returns the corrected byte pair together with carry, half-carry, zero, sign and parity flags. Two of the operations work on packed digits, with two decimal digits in one byte. The other two work on unpacked digits, with one digit per byte, and move the decimal carry or borrow into the high byte.

The unit sits in an execution datapath beside the integer adder. It has no clock and no state. Its outputs follow its inputs within the same cycle, so the surrounding pipeline registers the result. There is no data stream through the unit and no handshake, so back-pressure does not arise. All pins are plain control and data signals.

Top module: `decimal_adjust_unit`

## Requirements
- R1: `op_sel` encodes the operation as follows: 0 packed add-adjust, 1 packed subtract-adjust, 2 unpacked add-adjust, 3 unpacked subtract-adjust. For both packed operations `ah_out` equals `ah_in`.
- R2: Packed add-adjust, low digit. If `al_in[3:0]` > 9 or `af_in` is 1, 6 is added to the byte (modulo 256) and `af_out` is 1; otherwise `af_out` is 0.
- R3: Packed add-adjust, high digit. If the original `al_in` > 0x99 or `cf_in` is 1, 0x60 is added (modulo 256) to the result of R2 and `cf_out` is 1; otherwise `cf_out` is 0.
- R4: Packed subtract-adjust, low digit. If `al_in[3:0]` > 9 or `af_in` is 1, then `af_out` is 1 and 6 is subtracted (modulo 256). In that case `cf_out` is also 1 whenever `al_in` < 6 or `cf_in` is 1. Otherwise `af_out` is 0.
- R5: Packed subtract-adjust, high digit. If the original `al_in` > 0x99 or `cf_in` is 1, 0x60 is subtracted (modulo 256) from the result of R4 and `cf_out` is 1. If neither R4 nor R5 sets `cf_out`, it is 0.
- R6: For packed operations the flags come from the final `al_out`. `zf_out` is 1 when `al_out` is zero. `sf_out` is `al_out[7]`. `pf_out` is 1 when `al_out` has an even number of one bits.
- R7: Unpacked add-adjust with the condition met (`al_in[3:0]` > 9 or `af_in` is 1) gives the following. `al_out` = (`al_in`+6) mod 16. `ah_out` = `ah_in`+1, plus 1 more when `al_in` > 0xF9 (modulo 256). `cf_out` and `af_out` are both 1.
- R8: Unpacked subtract-adjust with the same condition met gives the following. `al_out` = (`al_in`-6) mod 16. `ah_out` = `ah_in`-1, minus 1 more when `al_in` < 6 (modulo 256). `cf_out` and `af_out` are both 1.
- R9: Unpacked operations with the condition not met give the following. `al_out` = `al_in[3:0]` zero-extended, `ah_out` = `ah_in`, and `cf_out` and `af_out` are both 0.
- R10: For unpacked operations `al_out[7:4]` is always 0 and `cf_out` always equals `af_out`. In these modes `zf_out`, `sf_out` and `pf_out` are don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code (see R1) |
| al_in | input | 8 | Low accumulator byte |
| ah_in | input | 8 | High accumulator byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming half-carry flag |
| al_out | output | 8 | Adjusted low byte |
| ah_out | output | 8 | Adjusted high byte |
| cf_out | output | 1 | Outgoing carry flag |
| af_out | output | 1 | Outgoing half-carry flag |
| zf_out | output | 1 | Zero flag of `al_out` |
| sf_out | output | 1 | Sign flag of `al_out` |
| pf_out | output | 1 | Even-parity flag of `al_out` |

## Verification
The hardest corners to reach are the ones where the operation code and the incoming flags combine to reach a rare carry path. One is the unpacked subtract double borrow: it needs `al_in` below 6, where the low digit alone never triggers the fix, so `af_in` must be forced high. Another is packed subtract with both a low-digit borrow and the 0x99 threshold active. The bench sweeps all four operations over every `al_in` value and all four combinations of `cf_in` and `af_in`. It repeats this for high bytes of 0x00 and 0xFF, so the increment and decrement wrap at the byte edges, plus two interior high bytes. Every one of those corners therefore comes up by construction.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  typedef enum logic [1:0] {
    ADJ_PK_ADD = 2'd0,
    ADJ_PK_SUB = 2'd1,
    ADJ_UN_ADD = 2'd2,
    ADJ_UN_SUB = 2'd3
  } adj_op_e;
endpackage

// File: rtl/dadj_packed.sv
// Two-digit (packed) correction step; SUBTRACT selects the borrow variant.
module dadj_packed #(
  parameter bit SUBTRACT = 1'b0,
  parameter int BYTE_W   = 8
) (
  input  logic [BYTE_W-1:0] val_i,
  input  logic              cy_i,
  input  logic              aux_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              cy_o,
  output logic              aux_o
);
  localparam int NIB_W = BYTE_W / 2;
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);
  localparam logic [BYTE_W-1:0] LO_STEP  = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_STEP  = BYTE_W'(6 << NIB_W);
  localparam logic [BYTE_W-1:0] HI_LIMIT = BYTE_W'((9 << NIB_W) | 9);

  logic              lo_fix, hi_fix;
  logic [BYTE_W-1:0] mid;

  always_comb begin
    lo_fix = (val_i[NIB_W-1:0] > NIB_MAX) || aux_i;
    hi_fix = (val_i > HI_LIMIT) || cy_i;
    aux_o  = lo_fix;
  end

  generate
    if (SUBTRACT) begin : g_sub
      always_comb begin
        mid   = lo_fix ? (val_i - LO_STEP) : val_i;
        res_o = hi_fix ? (mid - HI_STEP) : mid;
        cy_o  = hi_fix || (lo_fix && (val_i < LO_STEP));
      end
    end else begin : g_add
      always_comb begin
        mid   = lo_fix ? (val_i + LO_STEP) : val_i;
        res_o = hi_fix ? (mid + HI_STEP) : mid;
        cy_o  = hi_fix;
      end
    end
  endgenerate
endmodule

// File: rtl/dadj_unpacked.sv
// One-digit-per-byte correction; carry or borrow moves into the high byte.
module dadj_unpacked #(
  parameter bit SUBTRACT = 1'b0,
  parameter int BYTE_W   = 8
) (
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              aux_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cy_o,
  output logic              aux_o
);
  localparam int NIB_W = BYTE_W / 2;
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);
  localparam logic [BYTE_W-1:0] LO_STEP  = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] WRAP_LIM = {BYTE_W{1'b1}} - LO_STEP;
  localparam logic [BYTE_W-1:0] ONE      = BYTE_W'(1);

  logic              fix, extra;
  logic [BYTE_W-1:0] step, extra_w;

  always_comb begin
    fix     = (lo_i[NIB_W-1:0] > NIB_MAX) || aux_i;
    extra   = SUBTRACT ? (lo_i < LO_STEP) : (lo_i > WRAP_LIM);
    extra_w = {{(BYTE_W-1){1'b0}}, extra};
    step    = SUBTRACT ? (lo_i - LO_STEP) : (lo_i + LO_STEP);
    cy_o    = fix;
    aux_o   = fix;
    if (fix) begin
      lo_o = {{(BYTE_W-NIB_W){1'b0}}, step[NIB_W-1:0]};
      hi_o = SUBTRACT ? (hi_i - ONE - extra_w) : (hi_i + ONE + extra_w);
    end else begin
      lo_o = {{(BYTE_W-NIB_W){1'b0}}, lo_i[NIB_W-1:0]};
      hi_o = hi_i;
    end
  end
endmodule

// File: rtl/dadj_flags.sv
module dadj_flags #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] val_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  always_comb begin
    zf_o = ~|val_i;
    sf_o = val_i[BYTE_W-1];
    pf_o = ~^val_i;
  end
endmodule

// File: rtl/decimal_adjust_unit.sv
module decimal_adjust_unit
  import dadj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [1:0]        op_sel,
  input  logic [BYTE_W-1:0] al_in,
  input  logic [BYTE_W-1:0] ah_in,
  input  logic              cf_in,
  input  logic              af_in,
  output logic [BYTE_W-1:0] al_out,
  output logic [BYTE_W-1:0] ah_out,
  output logic              cf_out,
  output logic              af_out,
  output logic              zf_out,
  output logic              sf_out,
  output logic              pf_out
);
  localparam int N_VAR = 2;  // index 0 add, index 1 subtract

  logic [BYTE_W-1:0] pk_res [N_VAR];
  logic              pk_cy  [N_VAR];
  logic              pk_aux [N_VAR];
  logic [BYTE_W-1:0] un_lo  [N_VAR];
  logic [BYTE_W-1:0] un_hi  [N_VAR];
  logic              un_cy  [N_VAR];
  logic              un_aux [N_VAR];

  generate
    for (genvar g = 0; g < N_VAR; g++) begin : g_var
      dadj_packed #(.SUBTRACT(g != 0), .BYTE_W(BYTE_W)) u_pk (
        .val_i(al_in), .cy_i(cf_in), .aux_i(af_in),
        .res_o(pk_res[g]), .cy_o(pk_cy[g]), .aux_o(pk_aux[g])
      );
      dadj_unpacked #(.SUBTRACT(g != 0), .BYTE_W(BYTE_W)) u_un (
        .lo_i(al_in), .hi_i(ah_in), .aux_i(af_in),
        .lo_o(un_lo[g]), .hi_o(un_hi[g]), .cy_o(un_cy[g]), .aux_o(un_aux[g])
      );
    end
  endgenerate

  adj_op_e op;

  always_comb begin
    op = adj_op_e'(op_sel);
    unique case (op)
      ADJ_PK_ADD: begin al_out = pk_res[0]; ah_out = ah_in;    cf_out = pk_cy[0]; af_out = pk_aux[0]; end
      ADJ_PK_SUB: begin al_out = pk_res[1]; ah_out = ah_in;    cf_out = pk_cy[1]; af_out = pk_aux[1]; end
      ADJ_UN_ADD: begin al_out = un_lo[0];  ah_out = un_hi[0]; cf_out = un_cy[0]; af_out = un_aux[0]; end
      default:    begin al_out = un_lo[1];  ah_out = un_hi[1]; cf_out = un_cy[1]; af_out = un_aux[1]; end
    endcase
  end

  dadj_flags #(.BYTE_W(BYTE_W)) u_flags (
    .val_i(al_out), .zf_o(zf_out), .sf_o(sf_out), .pf_o(pf_out)
  );
endmodule

// File: rtl/dadj_checker.sv
module dadj_checker #(
  parameter int BYTE_W = 8
) (
  input logic [1:0]        op_sel,
  input logic [BYTE_W-1:0] al_in,
  input logic [BYTE_W-1:0] ah_in,
  input logic              cf_in,
  input logic              af_in,
  input logic [BYTE_W-1:0] al_out,
  input logic [BYTE_W-1:0] ah_out,
  input logic              cf_out,
  input logic              af_out,
  input logic              zf_out,
  input logic              sf_out
);
  localparam int NIB_W = BYTE_W / 2;

  always_comb begin
    if (!op_sel[1]) begin
      a_r1_packed_hi_kept: assert (ah_out == ah_in);
      a_r6_zero_flag: assert (zf_out == (al_out == '0));
      a_r6_sign_flag: assert (sf_out == al_out[BYTE_W-1]);
      if (cf_in) a_r3_r5_carry_sticky: assert (cf_out);
      if (af_in) a_r2_r4_aux_sticky: assert (af_out);
    end else begin
      a_r10_upper_clear: assert (al_out[BYTE_W-1:NIB_W] == '0);
      a_r10_flags_match: assert (cf_out == af_out);
      if (!af_out) a_r9_hi_kept: assert (ah_out == ah_in);
    end
  end
endmodule

bind decimal_adjust_unit dadj_checker #(.BYTE_W(BYTE_W)) u_dadj_checker (
  .op_sel(op_sel), .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
  .al_out(al_out), .ah_out(ah_out), .cf_out(cf_out), .af_out(af_out),
  .zf_out(zf_out), .sf_out(sf_out)
);

// File: tb/decimal_adjust_unit_bench.sv
`timescale 1ns/1ps
module decimal_adjust_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [1:0] op_sel;
  logic [7:0] al_in, ah_in, al_out, ah_out;
  logic cf_in, af_in, cf_out, af_out, zf_out, sf_out, pf_out;

  decimal_adjust_unit u_decimal_adjust_unit (
    .op_sel(op_sel), .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
    .al_out(al_out), .ah_out(ah_out), .cf_out(cf_out), .af_out(af_out),
    .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d al=%02h ah=%02h cf=%0b af=%0b: actual %0h expected %0h",
               tag, what, op_sel, al_in, ah_in, cf_in, af_in, act, exp);
    end
  endtask

  function automatic int even_par(input int v);
    int c = 0;
    for (int b = 0; b < 8; b++) c += (v >> b) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  task automatic apply(input int op, input int al, input int ah, input int cf, input int af);
    int e_al, e_ah, e_cf, e_af, lo;
    bit fix, hi;
    string tl, th;
    @(negedge clk);
    op_sel = op[1:0]; al_in = al[7:0]; ah_in = ah[7:0]; cf_in = cf[0]; af_in = af[0];
    @(posedge clk); #1;
    lo  = al % 16;
    fix = (lo > 9) || (af != 0);
    hi  = (al > 153) || (cf != 0);
    e_ah = ah; e_cf = 0; e_af = 0; e_al = al;
    case (op)
      0: begin  // R2 R3 packed add
        if (fix) begin e_al = (e_al + 6) % 256; e_af = 1; end
        if (hi)  begin e_al = (e_al + 96) % 256; e_cf = 1; end
        tl = "R2"; th = "R3";
      end
      1: begin  // R4 R5 packed subtract
        if (fix) begin
          e_af = 1;
          if (al < 6 || cf != 0) e_cf = 1;
          e_al = (e_al + 250) % 256;
        end
        if (hi) begin e_al = (e_al + 160) % 256; e_cf = 1; end
        tl = "R4"; th = "R5";
      end
      2: begin
        if (fix) begin
          e_al = (al + 6) % 16; e_ah = (ah + 1 + ((al > 249) ? 1 : 0)) % 256;
          e_cf = 1; e_af = 1; tl = "R7";
        end else begin
          e_al = lo; tl = "R9";
        end
        th = tl;
      end
      default: begin
        if (fix) begin
          e_al = (al + 256 - 6) % 16; e_ah = (ah + 512 - 1 - ((al < 6) ? 1 : 0)) % 256;
          e_cf = 1; e_af = 1; tl = "R8";
        end else begin
          e_al = lo; tl = "R9";
        end
        th = tl;
      end
    endcase
    chk(hi && op < 2 ? th : tl, "al_out", int'(al_out), e_al);
    chk(op < 2 ? "R1" : tl, "ah_out", int'(ah_out), e_ah);
    chk(op < 2 ? th : tl, "cf_out", int'(cf_out), e_cf);
    chk(tl, "af_out", int'(af_out), e_af);
    if (op < 2) begin
      chk("R6", "zf_out", int'(zf_out), (e_al == 0) ? 1 : 0);
      chk("R6", "sf_out", int'(sf_out), (e_al >> 7) & 1);
      chk("R6", "pf_out", int'(pf_out), even_par(e_al));
    end else begin
      chk("R10", "al_out upper", int'(al_out[7:4]), 0);
      chk("R10", "cf==af", int'(cf_out == af_out), 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int ah_set [4] = '{0, 255, 90, 128};
    op_sel = 2'd0; al_in = 8'h00; ah_in = 8'h00; cf_in = 1'b0; af_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // idle inputs: packed add of zero gives zero with zero and parity flags set (R6)
    chk("R6", "idle al_out", int'(al_out), 0);
    chk("R6", "idle zf_out", int'(zf_out), 1);
    chk("R6", "idle pf_out", int'(pf_out), 1);
    chk("R3", "idle cf_out", int'(cf_out), 0);
    // directed corners
    apply(0, 'h9A, 'h00, 0, 0);   // R3: 0x9A -> 0x00 with carry
    apply(1, 'h03, 'h00, 0, 1);   // R4: borrow from low digit
    apply(2, 'hFA, 'hFF, 0, 0);   // R7: double increment wraps
    apply(3, 'h02, 'h00, 0, 1);   // R8: double decrement wraps
    // sweep
    for (int h = 0; h < 4; h++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 256; a++)
          for (int f = 0; f < 4; f++)
            apply(op, a, ah_set[h], f & 1, f >> 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule